// File: doc/BRIEF.md
# Windowed Sample Monitor with Atomic Thresholds

This block watches a stream of 16-bit channel samples and flags when they leave a window bounded by a lower and an upper limit. Both limits are 16 bits wide but are loaded over an 8-bit register bus. Each limit takes two byte writes. A single holding byte collects the low half, and the upper-half write commits both halves in the same clock edge. A half-updated limit therefore never reaches the comparator.

Each sample that falls outside the window extends a run of consecutive misses. When the run reaches a programmed persistence count, a status flag is set. The flag stays set until software clears it. An interrupt line follows the flag while an enable input is high. The block sits between a bus slave, which supplies the address, data and strobes, and the sensor datapath that delivers the samples.

Top module: `thr_irq_top`

## Requirements
- R1: After synchronous reset, both limits read back as zero, the read data output is zero, and the status flag and interrupt output are low.
- R2: A write to a low-half address (0x84 for the lower limit, 0x86 for the upper limit) loads only the shared holding byte. Neither limit changes and neither readback changes.
- R3: A write to an upper-half address (0x85 for the lower limit, 0x87 for the upper limit) commits {written byte, holding byte} to that limit at the same clock edge. The holding byte keeps its value afterwards, so a later upper-half write reuses it.
- R4: The holding byte is shared. Writing 0x84 and then 0x87 loads all 16 bits into the upper limit and leaves the lower limit unchanged.
- R5: With reg_rd high at a clock edge, reg_rdata takes the committed byte of the addressed limit, with the low half at the even address and the high half at the odd address. It never shows the holding byte. Unmapped addresses read as zero, and writes to them change nothing.
- R6: A sample counts as out of range only when it is strictly below the lower limit or strictly above the upper limit. A sample equal to either limit is in range.
- R7: With persistence P from 1 to 15, the status flag is set at the clock edge that accepts the P-th consecutive out-of-range sample. Any in-range sample resets the run to zero. Cycles without a valid sample leave the run unchanged.
- R8: With persistence 0, every valid sample sets the status flag, whether it is in range or not.
- R9: The status flag stays set until stat_clr is high at a clock edge. If a clear and a set occur at the same edge, the flag stays set.
- R10: irq_out is registered. After each clock edge it equals the status flag ANDed with the irq_en value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data byte |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Registered read data |
| smp_valid | input | 1 | Sample strobe |
| smp_value | input | 16 | Sample value |
| pers_limit | input | 4 | Consecutive out-of-range count needed, 0 = every sample |
| irq_en | input | 1 | Interrupt enable |
| stat_clr | input | 1 | Clears the status flag |
| stat_flag | output | 1 | Sticky status flag |
| irq_out | output | 1 | Interrupt output |

## Verification
The assertions assume that every strobe lasts one cycle and that the inputs are stable when the clock edge samples them. They also assume that smp_valid stays low during reset, so the cycle before reset release shows no in-range sample. The bench drives all inputs on the falling edge, pulses each strobe for exactly one cycle, and holds smp_valid low for the whole reset period. Limits are reprogrammed only between samples, so every sample is compared against a fully committed window.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int NUM_THR = 2;
  localparam int THR_LOW = 0;
  localparam int THR_HIGH = 1;

  typedef struct packed {
    logic below;
    logic above;
  } thr_cmp_t;
endpackage

// File: rtl/thr_regfile.sv
module thr_regfile #(
  parameter int ADDR_W    = 8,
  parameter int BUS_W     = 8,
  parameter int BASE_ADDR = 'h84,
  parameter int NUM_THR   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BUS_W-1:0]     wdata,
  output logic [BUS_W-1:0]     rdata,
  output logic [2*BUS_W-1:0]   thr_o [NUM_THR]
);
  localparam int THR_W = 2 * BUS_W;

  logic [BUS_W-1:0] hold_q;
  logic [BUS_W-1:0] rd_mux;
  logic             lsb_hit;
  logic [THR_W-1:0] thr_q [NUM_THR];

  always_comb begin
    lsb_hit = 1'b0;
    rd_mux  = '0;
    for (int k = 0; k < NUM_THR; k++) begin
      if (addr == ADDR_W'(BASE_ADDR + 2 * k)) begin
        lsb_hit = 1'b1;
        rd_mux  = thr_q[k][BUS_W-1:0];
      end else if (addr == ADDR_W'(BASE_ADDR + 2 * k + 1)) begin
        rd_mux  = thr_q[k][THR_W-1:BUS_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else if (wr && lsb_hit) hold_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
    localparam logic [ADDR_W-1:0] MSB_A = ADDR_W'(BASE_ADDR + 2 * k + 1);

    always_ff @(posedge clk) begin
      if (rst) thr_q[k] <= '0;
      else if (wr && addr == MSB_A) thr_q[k] <= {wdata, hold_q};
    end

    assign thr_o[k] = thr_q[k];

    AST_MSB_COMMIT: assert property (@(posedge clk) disable iff (rst)
      (wr && addr == MSB_A) |=> (thr_q[k] == {$past(wdata), $past(hold_q)})); // R3
    AST_ONLY_MSB_CHANGES: assert property (@(posedge clk) disable iff (rst)
      !(wr && addr == MSB_A) |=> $stable(thr_q[k])); // R2
  end
endmodule

// File: rtl/thr_window_cmp.sv
module thr_window_cmp
  import thr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] lo_thr,
  input  logic [DATA_W-1:0] hi_thr,
  output thr_cmp_t          cmp
);
  always_comb begin
    cmp.below = (value < lo_thr);
    cmp.above = (value > hi_thr);
  end
endmodule

// File: rtl/thr_persist.sv
module thr_persist #(
  parameter int PERS_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic              oor,
  input  logic [PERS_W-1:0] pers_limit,
  input  logic              irq_en,
  input  logic              stat_clr,
  output logic              stat_o,
  output logic              irq_o
);
  localparam logic [PERS_W-1:0] CNT_MAX = '1;

  logic [PERS_W-1:0] cnt_q;
  logic [PERS_W-1:0] cnt_inc;
  logic              set_now;
  logic              stat_d;

  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    set_now = smp_valid &&
              ((pers_limit == '0) || (oor && cnt_inc >= pers_limit));
    if (set_now)       stat_d = 1'b1;
    else if (stat_clr) stat_d = 1'b0;
    else               stat_d = stat_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      stat_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (smp_valid) cnt_q <= oor ? cnt_inc : '0;
      stat_o <= stat_d;
      irq_o  <= stat_d && irq_en;
    end
  end

  AST_RUN_RESET: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !oor) |=> (cnt_q == '0)); // R7
  AST_SET_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_o) |-> $past(smp_valid)); // R7
  AST_ZERO_PERS_SETS: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && pers_limit == '0) |=> stat_o); // R8
  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_o) |-> $past(stat_clr)); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> stat_o); // R10
endmodule

// File: rtl/thr_irq_top.sv
module thr_irq_top
  import thr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int PERS_W    = 4,
  parameter int BASE_ADDR = 'h84
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W/2-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W/2-1:0] reg_rdata,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_value,
  input  logic [PERS_W-1:0] pers_limit,
  input  logic              irq_en,
  input  logic              stat_clr,
  output logic              stat_flag,
  output logic              irq_out
);
  localparam int BUS_W = DATA_W / 2;

  logic [DATA_W-1:0] thr [NUM_THR];
  thr_cmp_t          cmp;
  logic              oor;

  thr_regfile #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .BASE_ADDR(BASE_ADDR), .NUM_THR(NUM_THR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .thr_o(thr)
  );

  thr_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .value(smp_value), .lo_thr(thr[THR_LOW]), .hi_thr(thr[THR_HIGH]), .cmp(cmp)
  );

  assign oor = cmp.below | cmp.above;

  thr_persist #(.PERS_W(PERS_W)) u_pers (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .oor(oor),
    .pers_limit(pers_limit), .irq_en(irq_en), .stat_clr(stat_clr),
    .stat_o(stat_flag), .irq_o(irq_out)
  );

  AST_IN_WINDOW_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_value >= thr[THR_LOW] && smp_value <= thr[THR_HIGH]
     && pers_limit != '0 && !stat_flag && !stat_clr) |=> !stat_flag); // R6
endmodule

// File: tb/thr_irq_top_bench.sv
module thr_irq_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_value = '0;
  logic [3:0]  pers_limit = 4'd1;
  logic        irq_en = 1'b0;
  logic        stat_clr = 1'b0;
  logic        stat_flag;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  thr_irq_top u_thr_irq_top (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .smp_valid(smp_valid), .smp_value(smp_value), .pers_limit(pers_limit),
    .irq_en(irq_en), .stat_clr(stat_clr), .stat_flag(stat_flag), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic smp(input logic [15:0] v);
    @(negedge clk); smp_value = v; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rdata", 16'(reg_rdata), 16'h0);
    check("R1 stat", 16'(stat_flag), 16'h0);
    check("R1 irq", 16'(irq_out), 16'h0);
    for (int a = 'h84; a <= 'h87; a++) begin
      rd(8'(a), d);
      check("R1 readback", 16'(d), 16'h0);
    end
  endtask

  task automatic t_lsb_only();
    logic [7:0] d;
    wr(8'h84, 8'h34);
    rd(8'h84, d); check("R2 low lsb not committed", 16'(d), 16'h0);
    rd(8'h85, d); check("R2 low msb unchanged", 16'(d), 16'h0);
  endtask

  task automatic t_commit();
    logic [7:0] d;
    wr(8'h85, 8'h12);
    rd(8'h84, d); check("R3 low lsb", 16'(d), 16'h34);
    rd(8'h85, d); check("R3 low msb", 16'(d), 16'h12);
  endtask

  task automatic t_shared();
    logic [7:0] d;
    wr(8'h84, 8'hCD);
    wr(8'h87, 8'h56);
    rd(8'h86, d); check("R4 high lsb from shared byte", 16'(d), 16'hCD);
    rd(8'h87, d); check("R4 high msb", 16'(d), 16'h56);
    rd(8'h84, d); check("R4 low untouched", 16'(d), 16'h34);
    wr(8'h85, 8'h12);
    rd(8'h84, d); check("R3 holding byte reused", 16'(d), 16'hCD);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(8'h10, 8'hFF);
    rd(8'h10, d); check("R5 unmapped reads zero", 16'(d), 16'h0);
    rd(8'h84, d); check("R5 low lsb after unmapped write", 16'(d), 16'hCD);
    rd(8'h87, d); check("R5 high msb after unmapped write", 16'(d), 16'h56);
  endtask

  task automatic t_compare();
    pers_limit = 4'd1;
    clr();
    smp(16'h12CD); check("R6 equal low in range", 16'(stat_flag), 16'h0);
    smp(16'h56CD); check("R6 equal high in range", 16'(stat_flag), 16'h0);
    smp(16'h12CC); check("R6 below low", 16'(stat_flag), 16'h1);
    clr();         check("R9 clear", 16'(stat_flag), 16'h0);
    smp(16'h56CE); check("R6 above high", 16'(stat_flag), 16'h1);
  endtask

  task automatic t_persist();
    pers_limit = 4'd3;
    clr();
    smp(16'h3000);
    smp(16'h0001); smp(16'h0001);
    check("R7 two of three", 16'(stat_flag), 16'h0);
    smp(16'h3000);
    check("R7 in-range resets run", 16'(stat_flag), 16'h0);
    smp(16'hFFFF); smp(16'h0001);
    check("R7 run restarted", 16'(stat_flag), 16'h0);
    repeat (3) @(negedge clk);
    smp(16'hFFFF);
    check("R7 third consecutive sets", 16'(stat_flag), 16'h1);
  endtask

  task automatic t_pers0();
    pers_limit = 4'd0;
    clr();
    check("R9 cleared before zero-pers test", 16'(stat_flag), 16'h0);
    smp(16'h3000);
    check("R8 in-range sample sets", 16'(stat_flag), 16'h1);
  endtask

  task automatic t_sticky();
    pers_limit = 4'd1;
    smp(16'h3000); smp(16'h3000);
    check("R9 flag held", 16'(stat_flag), 16'h1);
    @(negedge clk); stat_clr = 1'b1; smp_value = 16'h0000; smp_valid = 1'b1;
    @(negedge clk); stat_clr = 1'b0; smp_valid = 1'b0;
    check("R9 set wins over clear", 16'(stat_flag), 16'h1);
    clr();
    check("R9 clear alone", 16'(stat_flag), 16'h0);
  endtask

  task automatic t_irq();
    pers_limit = 4'd1;
    irq_en = 1'b0;
    smp(16'h0000);
    check("R10 flag set", 16'(stat_flag), 16'h1);
    check("R10 disabled", 16'(irq_out), 16'h0);
    @(negedge clk); irq_en = 1'b1;
    @(negedge clk); check("R10 enabled", 16'(irq_out), 16'h1);
    irq_en = 1'b0;
    @(negedge clk); check("R10 enable dropped", 16'(irq_out), 16'h0);
    irq_en = 1'b1;
    @(negedge clk); check("R10 re-enabled", 16'(irq_out), 16'h1);
    clr();
    check("R10 clear drops irq", 16'(irq_out), 16'h0);
    check("R9 clear drops flag", 16'(stat_flag), 16'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lsb_only();
    t_commit();
    t_shared();
    t_unmapped();
    t_compare();
    t_persist();
    t_pers0();
    t_sticky();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule